// File: doc/BRIEF.md
# Remote DMA Host Data Port

This block gives a host processor byte-serial access to a controller's private buffer memory through one data port. The host loads a 16-bit start address and a 16-bit transfer length, each as two separate byte writes into a small register file. It then reads or writes the data port as often as needed. Every accepted access uses the current address and then moves it forward, and the remaining length shrinks by the same amount. Read data comes back on the cycle after the access.

The address space the port can reach has three regions. The low 32 bytes are a read-only identification region built from a 48-bit station address input. A buffer window of `RAM_BYTES` bytes starts at `RAM_BASE`; the full-size setting is 16 KiB at 0x4000. Every other address reads as all ones and takes no writes. A configuration bit sets whether accesses are byte-wide or word-wide. An access of the other width is refused, as is a misaligned word or an access with no length left.

The block also keeps two status flags. One marks a finished transfer. The other marks that the controller is in its reset/stopped state. An interrupt output follows the completion flag when a mask bit enables it.

Top module: `rdma_port`

## Requirements
- R1: After synchronous reset, `dma_addr` and `dma_count` are 0, `status` is 0x80, `irq` is 0 and byte-wide mode is selected.
- R2: A register write to select 0 (bits 7:0 of the start) or select 1 (bits 15:8) updates that half of the start value and loads the whole updated start into `dma_addr` at the same edge. This load takes priority over a data-port advance in the same cycle.
- R3: A write to select 2 replaces only bits 7:0 of `dma_count`, and a write to select 3 replaces only bits 15:8. The other half is kept, and the written half takes priority over a same-cycle decrement.
- R4: Select 7 bit 0 chooses the access width: 0 for byte, 1 for word. A data-port access whose `dp_word` differs from that bit, or that asserts `dp_rd` and `dp_wr` together, is refused. A refused access pulses `dp_err` on the following cycle and changes nothing.
- R5: An accepted access advances `dma_addr` by 1 for a byte or 2 for a word. It lowers `dma_count` by the same amount, stopping at 0.
- R6: A word access while `dma_addr` is odd is refused in the same way as R4.
- R7: A data-port access while `dma_count` is 0 is refused in the same way as R4.
- R8: An accepted data-port write that brings `dma_count` to 0 sets the completion flag, `status` bit 6. A read that reaches 0 does not set it.
- R9: A write to select 6 is a command, with bits 5:3 as the action code, bit 1 as start and bit 0 as stop. A command whose code is 0 is ignored entirely. Otherwise:
  - the started state takes bit 1;
  - setting start while not yet started clears `status` bit 7, and otherwise a stop bit sets it;
  - code 1 with start set while `dma_count` is 0 sets the completion flag at once.
- R10: A write to select 4 clears `status` bit 6 when data bit 6 is 1 and never changes bit 7. If a completion event falls in the same cycle, the flag ends set.
- R11: `irq` equals `status` bit 6 AND the mask bit, where the mask bit is select 5 data bit 6.
- R12: Addresses 0 to 31 read the identification region. Byte 2k and byte 2k+1 (k = 0 to 5) both hold `station_addr[8k+7:8k]`, and bytes 12 to 31 hold 0x57.
- R13: Addresses from `RAM_BASE` to `RAM_BASE+RAM_BYTES-1` read and write the buffer memory. Other addresses read 0xFF per byte and ignore writes. A word access is little-endian: the even address is bits 7:0, and a byte read returns bits 15:8 as 0.
- R14: `dp_rvalid` is high for exactly the cycle after an accepted read, with `dp_rdata` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| station_addr | input | 48 | Station address; byte k in bits 8k+7:8k |
| dp_rd | input | 1 | Data-port read request |
| dp_wr | input | 1 | Data-port write request |
| dp_word | input | 1 | Access width of this request (1 = word) |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Data-port read data |
| dp_rvalid | output | 1 | Read data valid |
| dp_err | output | 1 | Refused-access pulse |
| dma_addr | output | 16 | Current transfer address |
| dma_count | output | 16 | Remaining byte count |
| status | output | 8 | Bit 7 reset/stopped flag, bit 6 completion flag |
| irq | output | 1 | Masked completion interrupt |

## Verification
The completion flag can be set and cleared in the same cycle. The last data-port write of a transfer can coincide with a status write that clears bit 6. The bench provokes this by driving both requests on one clock edge. It judges the case by reading `status` afterwards and expecting the flag still set, with the interrupt following it. A second overlap, a start-address byte write landing on the same edge as a data access, is not the focus. The bench compares all other traffic against a byte-accurate memory and register model that it drives with seeded random transfers.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int          ROM_BYTES  = 32;
    localparam int          ROM_MIRROR = 12;
    localparam logic [7:0]  ROM_FILL   = 8'h57;
    localparam logic [2:0]  CODE_RDPROBE = 3'd1;

    typedef enum logic [2:0] {
        SEL_START_LO = 3'd0,
        SEL_START_HI = 3'd1,
        SEL_COUNT_LO = 3'd2,
        SEL_COUNT_HI = 3'd3,
        SEL_STATUS   = 3'd4,
        SEL_MASK     = 3'd5,
        SEL_CMD      = 3'd6,
        SEL_CFG      = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        RG_ROM  = 2'd0,
        RG_RAM  = 2'd1,
        RG_NONE = 2'd2
    } region_e;

    // accepted data-port access, handed from the control unit to memory
    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        word;
        logic [15:0] addr;
        logic [15:0] wdata;
    } dp_acc_t;

    function automatic region_e region_of(input logic [15:0] a,
                                          input logic [15:0] base,
                                          input logic [16:0] lim);
        logic [15:0] off;
        off = a - base;
        if (a < 16'(ROM_BYTES))
            return RG_ROM;
        else if ((a >= base) && ({1'b0, off} < lim))
            return RG_RAM;
        else
            return RG_NONE;
    endfunction

    function automatic logic [7:0] rom_byte(input logic [47:0] st,
                                            input logic [4:0]  idx);
        if (int'(idx) < ROM_MIRROR)
            return st[8*int'(idx[4:1]) +: 8];
        else
            return ROM_FILL;
    endfunction

endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
    import rdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    input  logic        dp_rd,
    input  logic        dp_wr,
    input  logic        dp_word,
    input  logic [15:0] dp_wdata,
    output dp_acc_t     acc,
    output logic [15:0] cur_addr,
    output logic [15:0] byte_cnt,
    output logic [7:0]  status,
    output logic        irq,
    output logic        acc_err
);

    logic [15:0] start_q, cnt_q, addr_q, step;
    logic        word_cfg_q, started_q, done_q, rstf_q, mask_q, err_q;
    logic        wr_slo, wr_shi, wr_clo, wr_chi, wr_stat, wr_mask, wr_cmd, wr_cfg;
    logic        req, ok, cmd_take, cmd_start, cmd_stop, zero_probe, wr_done;
    logic        done_set, done_clr;
    logic [2:0]  cmd_code;

    assign wr_slo  = reg_we && (reg_sel == SEL_START_LO);
    assign wr_shi  = reg_we && (reg_sel == SEL_START_HI);
    assign wr_clo  = reg_we && (reg_sel == SEL_COUNT_LO);
    assign wr_chi  = reg_we && (reg_sel == SEL_COUNT_HI);
    assign wr_stat = reg_we && (reg_sel == SEL_STATUS);
    assign wr_mask = reg_we && (reg_sel == SEL_MASK);
    assign wr_cmd  = reg_we && (reg_sel == SEL_CMD);
    assign wr_cfg  = reg_we && (reg_sel == SEL_CFG);

    assign step = dp_word ? 16'd2 : 16'd1;
    assign req  = dp_rd || dp_wr;
    assign ok   = req && !(dp_rd && dp_wr) && (dp_word == word_cfg_q)
                  && !(dp_word && addr_q[0]) && (cnt_q != 16'd0);

    assign acc.rd    = ok && dp_rd;
    assign acc.wr    = ok && dp_wr;
    assign acc.word  = dp_word;
    assign acc.addr  = addr_q;
    assign acc.wdata = dp_wdata;

    assign cmd_code   = reg_wdata[5:3];
    assign cmd_start  = reg_wdata[1];
    assign cmd_stop   = reg_wdata[0];
    assign cmd_take   = wr_cmd && (cmd_code != 3'd0);
    assign zero_probe = cmd_take && (cmd_code == CODE_RDPROBE) && cmd_start
                        && (cnt_q == 16'd0);
    assign wr_done    = acc.wr && (cnt_q <= step);
    assign done_set   = wr_done || zero_probe;
    assign done_clr   = wr_stat && reg_wdata[6];

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q    <= '0;
            cnt_q      <= '0;
            addr_q     <= '0;
            word_cfg_q <= 1'b0;
            started_q  <= 1'b0;
            done_q     <= 1'b0;
            rstf_q     <= 1'b1;
            mask_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            if (wr_slo) start_q[7:0]  <= reg_wdata;
            if (wr_shi) start_q[15:8] <= reg_wdata;

            if (wr_slo)      addr_q <= {start_q[15:8], reg_wdata};
            else if (wr_shi) addr_q <= {reg_wdata, start_q[7:0]};
            else if (ok)     addr_q <= addr_q + step;

            if (wr_clo)      cnt_q[7:0]  <= reg_wdata;
            else if (wr_chi) cnt_q[15:8] <= reg_wdata;
            else if (ok)     cnt_q <= (cnt_q > step) ? cnt_q - step : 16'd0;

            if (wr_cfg)  word_cfg_q <= reg_wdata[0];
            if (wr_mask) mask_q     <= reg_wdata[6];

            if (cmd_take) begin
                started_q <= cmd_start;
                if (cmd_start && !started_q) rstf_q <= 1'b0;
                else if (cmd_stop)           rstf_q <= 1'b1;
            end

            if (done_set)      done_q <= 1'b1;
            else if (done_clr) done_q <= 1'b0;

            err_q <= req && !ok;
        end
    end

    assign cur_addr = addr_q;
    assign byte_cnt = cnt_q;
    assign status   = {rstf_q, done_q, 6'b0};
    assign irq      = done_q && mask_q;
    assign acc_err  = err_q;

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (ok && !wr_slo && !wr_shi) |=> (addr_q == $past(addr_q) + $past(step)))
        else $error("address did not advance by access size");

    p_err_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (req && !ok && !reg_we) |=> ($stable(addr_q) && $stable(cnt_q) && $stable(done_q)))
        else $error("refused access changed state");

    p_rstflag_keep_r10: assert property (@(posedge clk) disable iff (rst)
        wr_stat |=> (rstf_q == $past(rstf_q)))
        else $error("status write touched reset flag");

    p_done_on_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (ok && dp_wr && (cnt_q <= step) && !reg_we) |=> (done_q && (cnt_q == 16'd0)))
        else $error("final write did not flag completion");

endmodule

// File: rtl/rdma_bufmem.sv
module rdma_bufmem
    import rdma_pkg::*;
#(
    parameter int unsigned RAM_BASE  = 16'h4000,
    parameter int unsigned RAM_BYTES = 2048
) (
    input  logic        clk,
    input  dp_acc_t     acc,
    output logic [15:0] rd_pair
);

    localparam int          BANK_DEPTH = RAM_BYTES / 2;
    localparam int          IDX_W      = $clog2(BANK_DEPTH);
    localparam logic [15:0] BASE16     = RAM_BASE[15:0];
    localparam logic [16:0] LIM17      = RAM_BYTES[16:0];

    logic [15:0]      off;
    logic             in_ram;
    logic [IDX_W-1:0] idx;
    logic [1:0]       bank_we;
    logic [7:0]       bank_wd [2];

    assign off    = acc.addr - BASE16;
    assign in_ram = (acc.addr >= BASE16) && ({1'b0, off} < LIM17);
    assign idx    = off[IDX_W:1];

    assign bank_we[0]  = acc.wr && in_ram && (acc.word || !off[0]);
    assign bank_we[1]  = acc.wr && in_ram && (acc.word ||  off[0]);
    assign bank_wd[0]  = acc.wdata[7:0];
    assign bank_wd[1]  = acc.word ? acc.wdata[15:8] : acc.wdata[7:0];

    // even bank holds bits 7:0 of a word, odd bank bits 15:8
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [7:0] mem [BANK_DEPTH];
        logic [7:0] rq;
        always_ff @(posedge clk) begin
            if (bank_we[b]) mem[idx] <= bank_wd[b];
            if (acc.rd)     rq <= mem[idx];
        end
        assign rd_pair[8*b +: 8] = rq;
    end

endmodule

// File: rtl/rdma_rdmux.sv
module rdma_rdmux
    import rdma_pkg::*;
#(
    parameter int unsigned RAM_BASE  = 16'h4000,
    parameter int unsigned RAM_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_rd,
    input  logic        acc_word,
    input  logic [15:0] acc_addr,
    input  logic [47:0] station,
    input  logic [15:0] rd_pair,
    output logic [15:0] rdata,
    output logic        rvalid
);

    localparam logic [15:0] BASE16 = RAM_BASE[15:0];
    localparam logic [16:0] LIM17  = RAM_BYTES[16:0];

    region_e    rg_q;
    logic [4:0] lo5_q;
    logic       word_q, rv_q;
    logic [7:0] lo_b, hi_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q   <= 1'b0;
            rg_q   <= RG_NONE;
            lo5_q  <= '0;
            word_q <= 1'b0;
        end else begin
            rv_q <= acc_rd;
            if (acc_rd) begin
                rg_q   <= region_of(acc_addr, BASE16, LIM17);
                lo5_q  <= acc_addr[4:0];
                word_q <= acc_word;
            end
        end
    end

    always_comb begin
        unique case (rg_q)
            RG_ROM: begin
                lo_b = rom_byte(station, lo5_q);
                hi_b = rom_byte(station, lo5_q | 5'd1);
            end
            RG_RAM: begin
                lo_b = (word_q || !lo5_q[0]) ? rd_pair[7:0] : rd_pair[15:8];
                hi_b = rd_pair[15:8];
            end
            default: begin
                lo_b = 8'hFF;
                hi_b = 8'hFF;
            end
        endcase
    end

    assign rdata  = word_q ? {hi_b, lo_b} : {8'h00, lo_b};
    assign rvalid = rv_q;

    p_rvalid_r14: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> rvalid)
        else $error("accepted read gave no valid data");

endmodule

// File: rtl/rdma_port.sv
module rdma_port
    import rdma_pkg::*;
#(
    parameter int unsigned RAM_BASE  = 16'h4000,
    parameter int unsigned RAM_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    input  logic [47:0] station_addr,
    input  logic        dp_rd,
    input  logic        dp_wr,
    input  logic        dp_word,
    input  logic [15:0] dp_wdata,
    output logic [15:0] dp_rdata,
    output logic        dp_rvalid,
    output logic        dp_err,
    output logic [15:0] dma_addr,
    output logic [15:0] dma_count,
    output logic [7:0]  status,
    output logic        irq
);

    dp_acc_t     acc;
    logic [15:0] rd_pair;

    rdma_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .dp_rd     (dp_rd),
        .dp_wr     (dp_wr),
        .dp_word   (dp_word),
        .dp_wdata  (dp_wdata),
        .acc       (acc),
        .cur_addr  (dma_addr),
        .byte_cnt  (dma_count),
        .status    (status),
        .irq       (irq),
        .acc_err   (dp_err)
    );

    rdma_bufmem #(.RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES)) u_mem (
        .clk     (clk),
        .acc     (acc),
        .rd_pair (rd_pair)
    );

    rdma_rdmux #(.RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES)) u_rdmux (
        .clk      (clk),
        .rst      (rst),
        .acc_rd   (acc.rd),
        .acc_word (acc.word),
        .acc_addr (acc.addr),
        .station  (station_addr),
        .rd_pair  (rd_pair),
        .rdata    (dp_rdata),
        .rvalid   (dp_rvalid)
    );

    p_irq_follows_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> status[6])
        else $error("interrupt without completion flag");

endmodule

// File: tb/tb_rdma_port.sv
module tb_rdma_port;

    localparam int unsigned BASE  = 16'h4000;
    localparam int unsigned BYTES = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [47:0] station_addr = 48'h665544332211;
    logic        dp_rd = 1'b0, dp_wr = 1'b0, dp_word = 1'b0;
    logic [15:0] dp_wdata = '0;
    logic [15:0] dp_rdata, dma_addr, dma_count;
    logic        dp_rvalid, dp_err, irq;
    logic [7:0]  status;

    rdma_port #(.RAM_BASE(BASE), .RAM_BYTES(BYTES)) dut (.*);

    always #4 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    logic done_run = 1'b0;

    // reference model
    logic [7:0]  m_mem [BYTES];
    logic [15:0] m_start = 0, m_addr = 0, m_cnt = 0;
    logic        m_word = 0, m_done = 0, m_rstf = 1, m_mask = 0, m_started = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic in_win(input logic [15:0] a);
        return (int'(a) >= int'(BASE)) && (int'(a) < int'(BASE + BYTES));
    endfunction

    function automatic logic [7:0] exp_byte(input logic [15:0] a);
        if (a < 16'd32) return (a < 16'd12) ? station_addr[8*int'(a[4:1]) +: 8] : 8'h57;
        if (in_win(a)) return m_mem[int'(a) - int'(BASE)];
        return 8'hFF;
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " addr"},   dma_addr,  m_addr);
        chk({tag, " count"},  dma_count, m_cnt);
        chk({tag, " status"}, status,    {m_rstf, m_done, 6'b0});
        chk({tag, " irq R11"}, irq,      m_done & m_mask);
    endtask

    task automatic reg_wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (s)
            3'd0: begin m_start[7:0] = d;  m_addr = m_start; end
            3'd1: begin m_start[15:8] = d; m_addr = m_start; end
            3'd2: m_cnt[7:0] = d;
            3'd3: m_cnt[15:8] = d;
            3'd4: if (d[6]) m_done = 1'b0;
            3'd5: m_mask = d[6];
            3'd6: if (d[5:3] != 3'd0) begin
                if (d[1] && !m_started) m_rstf = 1'b0;
                else if (d[0])          m_rstf = 1'b1;
                if (d[5:3] == 3'd1 && d[1] && m_cnt == 0) m_done = 1'b1;
                m_started = d[1];
            end
            default: m_word = d[0];
        endcase
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] n);
        reg_wr(3'd0, a[7:0]);  reg_wr(3'd1, a[15:8]);
        reg_wr(3'd2, n[7:0]);  reg_wr(3'd3, n[15:8]);
    endtask

    task automatic dp_acc(input string tag, input logic rd, input logic wr,
                          input logic word, input logic [15:0] wd);
        logic [15:0] step, exp_rd;
        logic        ok;
        step = word ? 16'd2 : 16'd1;
        ok = (rd || wr) && !(rd && wr) && (word == m_word) && !(word && m_addr[0]) && (m_cnt != 0);
        exp_rd = word ? {exp_byte(m_addr + 16'd1), exp_byte(m_addr)} : {8'h00, exp_byte(m_addr)};
        @(negedge clk);
        dp_rd = rd; dp_wr = wr; dp_word = word; dp_wdata = wd;
        @(negedge clk);
        dp_rd = 1'b0; dp_wr = 1'b0;
        if (ok) begin
            if (wr) begin
                for (int j = 0; j < int'(step); j++)
                    if (in_win(m_addr + 16'(j))) m_mem[int'(m_addr) + j - int'(BASE)] = wd[8*j +: 8];
                if (m_cnt <= step) m_done = 1'b1;
            end
            m_addr = m_addr + step;
            m_cnt  = (m_cnt > step) ? m_cnt - step : 16'd0;
        end
        chk({tag, " err"}, dp_err, !ok);
        chk({tag, " rvalid R14"}, dp_rvalid, ok && rd);
        if (ok && rd) chk({tag, " rdata"}, dp_rdata, exp_rd);
        check_state({tag, " R5"});
    endtask

    initial begin
        #(200000 * 8);
        if (!done_run) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_state("R1 reset");

        // R9 code-0 command ignored, then start clears reset flag
        reg_wr(3'd6, 8'h02);
        check_state("R9 code0 ignored");
        reg_wr(3'd6, 8'h12);
        check_state("R9 start");

        // R2 / R3 byte-split registers
        reg_wr(3'd0, 8'h34);
        chk("R2 low load", dma_addr, 16'h0034);
        reg_wr(3'd1, 8'h41);
        chk("R2 high load", dma_addr, 16'h4134);
        reg_wr(3'd3, 8'h12);
        chk("R3 high half", dma_count, 16'h1200);
        reg_wr(3'd2, 8'h05);
        chk("R3 low half", dma_count, 16'h1205);

        // R8 / R11 byte writes to completion with interrupt enabled
        reg_wr(3'd5, 8'h40);
        setup(16'h4000, 16'd3);
        dp_acc("R8 wr", 0, 1, 0, 16'h00A1);
        dp_acc("R8 wr", 0, 1, 0, 16'h00B2);
        chk("R8 not yet", status[6], 1'b0);
        dp_acc("R8 wr", 0, 1, 0, 16'h00C3);
        chk("R8 done", status[6], 1'b1);
        chk("R11 irq", irq, 1'b1);

        // R10 clear, reset flag unaffected
        reg_wr(3'd4, 8'hFF);
        check_state("R10 clear");
        reg_wr(3'd6, 8'h21);
        chk("R9 stop sets", status[7], 1'b1);
        reg_wr(3'd4, 8'hC0);
        chk("R10 bit7 kept", status[7], 1'b1);
        reg_wr(3'd6, 8'h22);

        // R8 reads reaching zero do not complete; R13 readback
        setup(16'h4000, 16'd3);
        dp_acc("R13 rd", 1, 0, 0, 0);
        dp_acc("R13 rd", 1, 0, 0, 0);
        dp_acc("R13 rd", 1, 0, 0, 0);
        chk("R8 read no done", status[6], 1'b0);

        // R7 zero count refused
        dp_acc("R7 zero", 1, 0, 0, 0);
        dp_acc("R7 zero", 0, 1, 0, 16'h0055);

        // R4 size mismatch, both strobes
        setup(16'h4010, 16'd4);
        dp_acc("R4 mismatch", 0, 1, 1, 16'h1234);
        dp_acc("R4 both", 1, 1, 0, 16'h0012);

        // R13 word mode little endian, R6 odd word
        reg_wr(3'd7, 8'h01);
        setup(16'h4020, 16'd4);
        dp_acc("R13 wword", 0, 1, 1, 16'hBEEF);
        dp_acc("R13 wword", 0, 1, 1, 16'hCAFE);
        setup(16'h4020, 16'd4);
        dp_acc("R13 rword", 1, 0, 1, 0);
        dp_acc("R13 rword", 1, 0, 1, 0);
        reg_wr(3'd7, 8'h00);
        setup(16'h4021, 16'd1);
        dp_acc("R13 byte odd", 1, 0, 0, 0);
        reg_wr(3'd7, 8'h01);
        setup(16'h4021, 16'd2);
        dp_acc("R6 odd word", 1, 0, 1, 0);

        // R12 identification region, word reads over all 32 bytes
        setup(16'h0000, 16'd32);
        for (int i = 0; i < 16; i++) dp_acc("R12 rom", 1, 0, 1, 0);

        // R13 outside the window: writes ignored, reads FF
        setup(16'(BASE + BYTES), 16'd2);
        dp_acc("R13 oob wr", 0, 1, 1, 16'h1111);
        setup(16'(BASE + BYTES), 16'd2);
        dp_acc("R13 oob rd", 1, 0, 1, 0);
        setup(16'h2000, 16'd2);
        dp_acc("R13 gap rd", 1, 0, 1, 0);
        reg_wr(3'd7, 8'h00);

        // R9 zero-length read probe
        reg_wr(3'd4, 8'h40);
        setup(16'h4000, 16'd0);
        reg_wr(3'd6, 8'h0A);
        chk("R9 probe done", status[6], 1'b1);
        reg_wr(3'd4, 8'h40);
        reg_wr(3'd6, 8'h12);
        check_state("R9 probe code2");

        // R10 collision: final write and clear in one cycle
        setup(16'h4100, 16'd1);
        @(negedge clk);
        dp_wr = 1'b1; dp_word = 1'b0; dp_wdata = 16'h005A;
        reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 8'h40;
        @(negedge clk);
        dp_wr = 1'b0; reg_we = 1'b0;
        m_mem[16'h4100 - BASE] = 8'h5A; m_addr = 16'h4101; m_cnt = 0; m_done = 1'b1;
        check_state("R10 collide");
        reg_wr(3'd4, 8'h40);

        // R2 same-cycle start load beats advance
        setup(16'h4200, 16'd4);
        @(negedge clk);
        dp_wr = 1'b1; dp_wdata = 16'h0077;
        reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 8'h80;
        @(negedge clk);
        dp_wr = 1'b0; reg_we = 1'b0;
        m_mem[16'h4200 - BASE] = 8'h77; m_start = 16'h4280; m_addr = 16'h4280; m_cnt = 3;
        check_state("R2 priority");

        // random transfers against the model
        for (int it = 0; it < 40; it++) begin
            logic        w;
            logic [15:0] a, n;
            w = 1'($urandom_range(0, 1));
            reg_wr(3'd7, {7'b0, w});
            a = 16'(BASE + $urandom_range(0, BYTES - 16));
            if (w) a[0] = 1'b0;
            n = 16'($urandom_range(1, 6));
            if (w) n = n * 2;
            setup(a, n);
            for (int k = 0; k < int'(n) / (w ? 2 : 1); k++)
                dp_acc("R5 rnd wr", 0, 1, w, 16'($urandom));
            setup(a, n);
            for (int k = 0; k < int'(n) / (w ? 2 : 1); k++)
                dp_acc("R13 rnd rd", 1, 0, w, 0);
            reg_wr(3'd4, 8'h40);
        end

        done_run = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule